// File: doc/BRIEF.md
# Relay Decoding Loop Controller

This block runs the outer loop of an iterative belief-propagation decoder that works in a series of legs. It issues one-cycle iteration strobes to an external BP core, which needs two clock cycles per iteration. After each iteration it reads the core's hard-decision vector and its residual syndrome. It counts the failing checks with a population count, and it keeps the lightest error pattern that clears the syndrome.

A leg ends in one of three ways: it reaches its iteration limit, its failing-check count stops improving for a patience window, or a valid pattern appears. At each new leg the leg index advances and a different row of per-node memory strengths is presented to the core. Beliefs are not reinitialised between legs. The decode ends when the syndrome clears, or when the last leg ends. At that point the block raises `done`, reports `success`, and presents the best correction found.

A parameter selects between two behaviours for a cleared syndrome. The block either stops at the first valid pattern, or it keeps gathering one valid pattern per leg and retains the lightest of them.

Top module: `relay_loop_ctrl`

## Requirements
- R1: `leg_idx` counts legs from 0 to N_LEGS-1, and `leg_strengths` shows row `leg_idx` of STRENGTH_TABLE. Row l occupies bits [l*N_VAR*STR_W +: N_VAR*STR_W], and node n sits at bits [n*STR_W +: STR_W] of its row.
- R2: `iter_strobe` is a one-cycle pulse.
  - The first strobe of a decode appears in the cycle after the clock edge that samples `start`.
  - Within a leg, consecutive strobes are exactly 2 cycles apart.
  - The first strobe of a new leg comes 3 cycles after the last strobe of the previous leg.
  - The core's `hard_dec` and `resid_syn` are sampled 2 cycles after each strobe.
- R3: `belief_init` is high only with the first strobe of a decode. Later legs start without it, so beliefs carry forward.
- R4: Solution weight is the popcount of `hard_dec`. An attempt is valid when `resid_syn` is all zeros. The kept pattern is replaced only by a valid attempt of strictly lower weight, so a tie keeps the earlier pattern. An invalid attempt is never kept.
- R5: Stall termination works as follows.
  - A stall count increments on each iteration whose failing-check count is not below the leg's minimum so far.
  - A new minimum clears the count, and every leg start clears it too.
  - The leg ends when the incremented count reaches `patience`.
  - `patience` = 0 disables this rule. `patience` must be held constant during a decode.
- R6: A leg never runs more than MAX_ITER iterations.
- R7: When STOP_ON_VALID=1, an all-zero `resid_syn` ends the decode at that iteration, in any leg. When STOP_ON_VALID=0, it ends only the current leg.
- R8: `done` rises in the cycle after the deciding evaluation.
  - With STOP_ON_VALID=1, `done` appears 4 cycles after `start` is asserted when the first iteration clears the syndrome.
  - `success` is high if and only if a pattern was kept.
  - `best_corr` holds that pattern, or zero if none was kept.
  - `done`, `success` and `best_corr` are held until the next accepted `start`.
- R9: `start` has no effect while a decode is running.
- R10: After reset, `done`, `success`, `iter_strobe` and `leg_idx` are 0, and `best_corr` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode when idle or done |
| patience | input | PAT_W | Stall window in iterations, 0 disables |
| hard_dec | input | N_VAR | Core hard decisions for the last iteration |
| resid_syn | input | N_CHK | Core residual syndrome for the last iteration |
| iter_strobe | output | 1 | Start one core iteration |
| belief_init | output | 1 | Load priors into the core (first strobe only) |
| leg_idx | output | LEG_W | Current leg |
| leg_strengths | output | N_VAR*STR_W | Memory-strength row for the current leg |
| done | output | 1 | Decode finished |
| success | output | 1 | A valid pattern was kept |
| best_corr | output | N_VAR | Lightest valid pattern found |

## Verification
The bench builds two instances with N_VAR=8, N_CHK=6, N_LEGS=3, MAX_ITER=6 and PAT_W=3. One instance stops at the first valid pattern, and the other gathers one pattern per leg. The short iteration limit and three legs keep a full no-progress decode to 18 iterations. That makes leg rollover, the strength row of every leg and the strobe cadence across leg boundaries cheap to reach. Patience 2 lets scripted failing-check sequences separate a stall counter that resets on a new minimum from one that does not. The gathering instance exposes tie handling in the keep-best register and the rejection of invalid light patterns.

// File: rtl/relay_pkg.sv
package relay_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_EVAL,
    ST_DONE
  } ctl_state_t;

  // Number of set bits; callers zero-extend to 256 bits.
  function automatic logic [8:0] count_ones(input logic [255:0] v);
    logic [8:0] c;
    c = '0;
    for (int i = 0; i < 256; i++) c = c + 9'(v[i]);
    return c;
  endfunction

  // True when a candidate should replace the kept pattern.
  function automatic logic beats_kept(input logic have_kept,
                                      input logic [8:0] cand_w,
                                      input logic [8:0] kept_w);
    return !have_kept || (cand_w < kept_w);
  endfunction

endpackage

// File: rtl/relay_strength_mux.sv
module relay_strength_mux #(
  parameter int N_LEGS = 3,
  parameter int ROW_W  = 32,
  parameter int LEG_W  = 2,
  parameter logic [N_LEGS*ROW_W-1:0] TABLE = '0
) (
  input  logic [LEG_W-1:0] leg_sel,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] picked [N_LEGS];

  for (genvar l = 0; l < N_LEGS; l++) begin : g_row
    assign picked[l] = (leg_sel == LEG_W'(l)) ? TABLE[l*ROW_W +: ROW_W] : '0;
  end

  always_comb begin
    row = '0;
    for (int l = 0; l < N_LEGS; l++) row = row | picked[l];
  end
endmodule

// File: rtl/relay_stall_track.sv
module relay_stall_track #(
  parameter int CNT_W = 3,
  parameter int PAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             leg_clear,
  input  logic             eval_fire,
  input  logic [CNT_W-1:0] fails,
  input  logic [PAT_W-1:0] patience,
  output logic [PAT_W-1:0] stall_cnt,
  output logic             new_min,
  output logic             stall_hit
);
  logic [CNT_W:0] min_fail;
  logic [PAT_W:0] stall_step;

  assign new_min    = {1'b0, fails} < min_fail;
  assign stall_step = {1'b0, stall_cnt} + 1'b1;
  assign stall_hit  = eval_fire && (patience != '0) && !new_min &&
                      (stall_step >= {1'b0, patience});

  always_ff @(posedge clk) begin
    if (!rst_n || leg_clear) begin
      min_fail  <= '1;
      stall_cnt <= '0;
    end else if (eval_fire) begin
      if (new_min) begin
        min_fail  <= {1'b0, fails};
        stall_cnt <= '0;
      end else if (!(&stall_cnt)) begin
        stall_cnt <= stall_step[PAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/relay_keep_best.sv
module relay_keep_best
  import relay_pkg::*;
#(
  parameter int N_VAR = 8,
  parameter int WT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             eval_fire,
  input  logic             cand_valid,
  input  logic [N_VAR-1:0] cand_vec,
  input  logic [WT_W-1:0]  cand_wt,
  output logic [N_VAR-1:0] best_vec,
  output logic [WT_W-1:0]  best_wt,
  output logic             best_valid,
  output logic             keep_upd
);
  assign keep_upd = eval_fire && cand_valid &&
                    beats_kept(best_valid, 9'(cand_wt), 9'(best_wt));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      best_vec   <= '0;
      best_wt    <= '0;
      best_valid <= 1'b0;
    end else if (keep_upd) begin
      best_vec   <= cand_vec;
      best_wt    <= cand_wt;
      best_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/relay_loop_ctrl.sv
module relay_loop_ctrl
  import relay_pkg::*;
#(
  parameter int N_VAR    = 8,
  parameter int N_CHK    = 6,
  parameter int N_LEGS   = 3,
  parameter int MAX_ITER = 6,
  parameter int STR_W    = 4,
  parameter int PAT_W    = 3,
  parameter bit STOP_ON_VALID = 1'b1,
  parameter logic [N_LEGS*N_VAR*STR_W-1:0] STRENGTH_TABLE = 96'h0F1E_2D3C_4B5A_6978_8796_A5B4,
  localparam int LEG_W = (N_LEGS > 1) ? $clog2(N_LEGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PAT_W-1:0]       patience,
  input  logic [N_VAR-1:0]       hard_dec,
  input  logic [N_CHK-1:0]       resid_syn,
  output logic                   iter_strobe,
  output logic                   belief_init,
  output logic [LEG_W-1:0]       leg_idx,
  output logic [N_VAR*STR_W-1:0] leg_strengths,
  output logic                   done,
  output logic                   success,
  output logic [N_VAR-1:0]       best_corr
);
  localparam int ROW_W = N_VAR * STR_W;
  localparam int CNT_W = $clog2(N_CHK + 1);
  localparam int WT_W  = $clog2(N_VAR + 1);
  localparam int IT_W  = $clog2(MAX_ITER + 1);

  ctl_state_t       state, nxt;
  logic [IT_W-1:0]  iter_cnt;
  logic [CNT_W-1:0] fails;
  logic [WT_W-1:0]  cand_wt, best_wt;
  logic [PAT_W-1:0] stall_cnt;
  logic             accept, launch, eval_fire, cand_valid, iter_last, last_leg;
  logic             leg_end, stop_now, leg_clear, stall_hit, new_min;
  logic             keep_upd, best_valid, go_on;

  // Internal events, named for the checker.
  assign accept     = start && (state == ST_IDLE || state == ST_DONE);
  assign launch     = (state == ST_LAUNCH);
  assign eval_fire  = (state == ST_EVAL);
  assign fails      = CNT_W'(count_ones(256'(resid_syn)));
  assign cand_wt    = WT_W'(count_ones(256'(hard_dec)));
  assign cand_valid = (fails == '0);
  assign iter_last  = (iter_cnt == IT_W'(MAX_ITER - 1));
  assign last_leg   = (leg_idx == LEG_W'(N_LEGS - 1));
  assign leg_end    = eval_fire && (cand_valid || stall_hit || iter_last);
  assign stop_now   = eval_fire && ((cand_valid && STOP_ON_VALID) || (leg_end && last_leg));
  assign go_on      = eval_fire && !leg_end;
  assign leg_clear  = accept || (leg_end && !stop_now);

  assign iter_strobe = launch || go_on;
  assign belief_init = launch && (leg_idx == '0);
  assign done        = (state == ST_DONE);
  assign success     = best_valid;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE: if (start) nxt = ST_LAUNCH;
      ST_LAUNCH:        nxt = ST_WAIT;
      ST_WAIT:          nxt = ST_EVAL;
      ST_EVAL: begin
        if (stop_now)     nxt = ST_DONE;
        else if (leg_end) nxt = ST_LAUNCH;
        else              nxt = ST_WAIT;
      end
      default:          nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      leg_idx  <= '0;
      iter_cnt <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        leg_idx  <= '0;
        iter_cnt <= '0;
      end else if (eval_fire) begin
        if (leg_end) begin
          iter_cnt <= '0;
          if (!stop_now) leg_idx <= LEG_W'(leg_idx + 1'b1);
        end else begin
          iter_cnt <= IT_W'(iter_cnt + 1'b1);
        end
      end
    end
  end

  relay_strength_mux #(
    .N_LEGS(N_LEGS), .ROW_W(ROW_W), .LEG_W(LEG_W), .TABLE(STRENGTH_TABLE)
  ) u_mux (
    .leg_sel(leg_idx),
    .row    (leg_strengths)
  );

  relay_stall_track #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .leg_clear(leg_clear),
    .eval_fire(eval_fire),
    .fails    (fails),
    .patience (patience),
    .stall_cnt(stall_cnt),
    .new_min  (new_min),
    .stall_hit(stall_hit)
  );

  relay_keep_best #(.N_VAR(N_VAR), .WT_W(WT_W)) u_best (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .eval_fire (eval_fire),
    .cand_valid(cand_valid),
    .cand_vec  (hard_dec),
    .cand_wt   (cand_wt),
    .best_vec  (best_corr),
    .best_wt   (best_wt),
    .best_valid(best_valid),
    .keep_upd  (keep_upd)
  );
endmodule

// File: rtl/relay_loop_ctrl_chk.sv
module relay_loop_ctrl_chk #(
  parameter int N_VAR    = 8,
  parameter int N_LEGS   = 3,
  parameter int MAX_ITER = 6,
  parameter int PAT_W    = 3,
  parameter int LEG_W    = 2,
  parameter int IT_W     = 3,
  parameter int CNT_W    = 3,
  parameter int WT_W     = 4,
  parameter bit STOP_ON_VALID = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             iter_strobe,
  input logic             belief_init,
  input logic [LEG_W-1:0] leg_idx,
  input logic             done,
  input logic             success,
  input logic [N_VAR-1:0] best_corr,
  input logic             eval_fire,
  input logic [IT_W-1:0]  iter_cnt,
  input logic [PAT_W-1:0] stall_cnt,
  input logic [PAT_W-1:0] patience,
  input logic [CNT_W-1:0] fails,
  input logic [WT_W-1:0]  best_wt,
  input logic             best_valid
);
  AST_LEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_strobe |-> (int'(leg_idx) < N_LEGS)); // R1
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    iter_strobe |=> !iter_strobe); // R2
  AST_INIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    belief_init |-> (iter_strobe && leg_idx == '0 && iter_cnt == '0)); // R3
  AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && $past(best_valid) && !$past(start)) |-> (best_wt <= $past(best_wt))); // R4
  AST_STALL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && patience != '0) |-> (stall_cnt < patience)); // R5
  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |-> (int'(iter_cnt) < MAX_ITER)); // R6
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (STOP_ON_VALID && eval_fire && fails == '0) |=> done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(best_corr) && $stable(success))); // R8
  AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iter_strobe); // R8
endmodule

bind relay_loop_ctrl relay_loop_ctrl_chk #(
  .N_VAR(N_VAR), .N_LEGS(N_LEGS), .MAX_ITER(MAX_ITER), .PAT_W(PAT_W),
  .LEG_W(LEG_W), .IT_W(IT_W), .CNT_W(CNT_W), .WT_W(WT_W),
  .STOP_ON_VALID(STOP_ON_VALID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iter_strobe(iter_strobe),
  .belief_init(belief_init), .leg_idx(leg_idx), .done(done), .success(success),
  .best_corr(best_corr), .eval_fire(eval_fire), .iter_cnt(iter_cnt),
  .stall_cnt(stall_cnt), .patience(patience), .fails(fails),
  .best_wt(best_wt), .best_valid(best_valid)
);

// File: tb/tb_relay_loop_ctrl.sv
module tb_relay_loop_ctrl;
  localparam int NV = 8, NC = 6, NL = 3, MI = 6, SW = 4, PW = 3;
  localparam int LW = 2, ROW = NV * SW;
  localparam logic [NL*ROW-1:0] TB_TABLE = 96'h0F1E_2D3C_4B5A_6978_8796_A5B4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // Instance that stops at the first valid pattern
  logic start = 1'b0;
  logic [PW-1:0] pat = '0;
  logic [NV-1:0] hd;
  logic [NC-1:0] syn;
  logic strobe, binit, done, success;
  logic [LW-1:0] leg;
  logic [ROW-1:0] strs;
  logic [NV-1:0] best;
  logic [NC-1:0] syn_s [32];
  logic [NV-1:0] hd_s  [32];
  int k = 0;

  // Gathering instance
  logic start_e = 1'b0;
  logic [NV-1:0] hd_e;
  logic [NC-1:0] syn_e;
  logic strobe_e, binit_e, done_e, success_e;
  logic [LW-1:0] leg_e;
  logic [ROW-1:0] strs_e;
  logic [NV-1:0] best_e;
  logic [NC-1:0] syn_es [32];
  logic [NV-1:0] hd_es  [32];
  int ke = 0;

  relay_loop_ctrl #(.N_VAR(NV), .N_CHK(NC), .N_LEGS(NL), .MAX_ITER(MI), .STR_W(SW),
    .PAT_W(PW), .STOP_ON_VALID(1'b1), .STRENGTH_TABLE(TB_TABLE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .patience(pat), .hard_dec(hd),
    .resid_syn(syn), .iter_strobe(strobe), .belief_init(binit), .leg_idx(leg),
    .leg_strengths(strs), .done(done), .success(success), .best_corr(best));

  relay_loop_ctrl #(.N_VAR(NV), .N_CHK(NC), .N_LEGS(NL), .MAX_ITER(MI), .STR_W(SW),
    .PAT_W(PW), .STOP_ON_VALID(1'b0), .STRENGTH_TABLE(TB_TABLE)) dut_ens (
    .clk(clk), .rst_n(rst_n), .start(start_e), .patience(3'd0), .hard_dec(hd_e),
    .resid_syn(syn_e), .iter_strobe(strobe_e), .belief_init(binit_e), .leg_idx(leg_e),
    .leg_strengths(strs_e), .done(done_e), .success(success_e), .best_corr(best_e));

  // Core models: the result of iteration j is script entry j-1, shown after its strobe.
  always @(posedge clk) begin
    if (binit) k <= 1; else if (strobe) k <= k + 1;
    if (binit_e) ke <= 1; else if (strobe_e) ke <= ke + 1;
  end
  assign syn   = syn_s[(k == 0) ? 0 : ((k - 1) & 31)];
  assign hd    = hd_s[(k == 0) ? 0 : ((k - 1) & 31)];
  assign syn_e = syn_es[(ke == 0) ? 0 : ((ke - 1) & 31)];
  assign hd_e  = hd_es[(ke == 0) ? 0 : ((ke - 1) & 31)];

  // Strobe monitors
  int cyc = 0, strobe_tot = 0, init_tot = 0, gap_bad = 0, str_bad = 0, last_cyc = 0;
  int last_leg = 0, strobe_tot_e = 0;
  int legcnt [4] = '{0, 0, 0, 0};
  int legcnt_e [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    cyc++;
    if (strobe) begin
      strobe_tot++;
      legcnt[leg]++;
      if (binit) init_tot++;
      else if ((cyc - last_cyc) != ((int'(leg) == last_leg) ? 2 : 3)) gap_bad++;
      last_cyc = cyc;
      last_leg = int'(leg);
      if (strs != TB_TABLE[int'(leg)*ROW +: ROW]) str_bad++;
    end
    if (strobe_e) begin
      strobe_tot_e++;
      legcnt_e[leg_e]++;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int from, input int upto, input logic [NC-1:0] s,
                      input logic [NV-1:0] h);
    for (int i = from; i <= upto; i++) begin
      syn_s[i] = s;
      hd_s[i]  = h;
    end
  endtask

  // Runs one decode on dut; returns cycles to done, strobe count and per-leg counts.
  task automatic go(input logic [PW-1:0] p, input bit mid_start, output int lat,
                    output int ns, output int l0, output int l1, output int l2,
                    output int ni, output int gb, output int sb);
    int b_s, b0, b1, b2, b_i, b_g, b_b;
    b_s = strobe_tot; b0 = legcnt[0]; b1 = legcnt[1]; b2 = legcnt[2];
    b_i = init_tot; b_g = gap_bad; b_b = str_bad;
    @(negedge clk);
    pat = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (mid_start) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    ns = strobe_tot - b_s; l0 = legcnt[0] - b0; l1 = legcnt[1] - b1; l2 = legcnt[2] - b2;
    ni = init_tot - b_i; gb = gap_bad - b_g; sb = str_bad - b_b;
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(success == 1'b0, "R10 success", int'(success), 0);
    chk(strobe == 1'b0, "R10 strobe", int'(strobe), 0);
    chk(leg == '0, "R10 leg", int'(leg), 0);
    chk(best == '0, "R10 best", int'(best), 0);
  endtask

  task automatic t_clear_first();
    int lat, ns, l0, l1, l2, ni, gb, sb;
    fill(0, 31, 6'b000111, 8'h00);
    fill(0, 0, 6'b000000, 8'h05);
    go(3'd3, 1'b0, lat, ns, l0, l1, l2, ni, gb, sb);
    chk(lat == 4, "R8 latency to done", lat, 4);
    chk(ns == 1, "R7 one iteration", ns, 1);
    chk(success == 1'b1, "R8 success", int'(success), 1);
    chk(best == 8'h05, "R8 best", int'(best), 5);
    chk(ni == 1, "R3 init once", ni, 1);
    repeat (3) @(negedge clk);
    chk(done && best == 8'h05, "R8 held", int'(best), 5);
  endtask

  task automatic t_no_progress();
    int lat, ns, l0, l1, l2, ni, gb, sb;
    fill(0, 31, 6'b000111, 8'h00);
    go(3'd0, 1'b1, lat, ns, l0, l1, l2, ni, gb, sb);
    chk(ns == 18, "R9 mid start ignored, strobes", ns, 18);
    chk(l0 == 6 && l1 == 6 && l2 == 6, "R6 per-leg cap", l0 * 100 + l1 * 10 + l2, 666);
    chk(ni == 1, "R3 no init on later legs", ni, 1);
    chk(gb == 0, "R2 strobe cadence", gb, 0);
    chk(sb == 0, "R1 strength row", sb, 0);
    chk(int'(leg) == 2, "R1 last leg index", int'(leg), 2);
    chk(success == 1'b0, "R8 no success", int'(success), 0);
    chk(best == '0, "R8 best zero", int'(best), 0);
  endtask

  task automatic t_stall();
    int lat, ns, l0, l1, l2, ni, gb, sb;
    fill(0, 31, 6'b000011, 8'h01);
    fill(0, 0, 6'b000111, 8'h00);
    go(3'd2, 1'b0, lat, ns, l0, l1, l2, ni, gb, sb);
    chk(l0 == 4 && l1 == 3 && l2 == 3, "R5 stall legs", l0 * 100 + l1 * 10 + l2, 433);
    chk(ns == 10, "R5 total", ns, 10);
    chk(success == 1'b0, "R8 no success after stall", int'(success), 0);
    chk(gb == 0, "R2 cadence across stall", gb, 0);
  endtask

  task automatic t_stall_reset();
    int lat, ns, l0, l1, l2, ni, gb, sb;
    fill(0, 31, 6'b000001, 8'h00);
    fill(0, 1, 6'b000111, 8'h00);
    fill(2, 3, 6'b000011, 8'h00);
    fill(6, 6, 6'b000000, 8'h81);
    go(3'd2, 1'b0, lat, ns, l0, l1, l2, ni, gb, sb);
    chk(l0 == 6, "R5 new minimum clears stall", l0, 6);
    chk(ns == 7, "R7 clear in leg 1", ns, 7);
    chk(int'(leg) == 1, "R7 stops in leg 1", int'(leg), 1);
    chk(best == 8'h81 && success, "R8 best after stall", int'(best), 8'h81);
  endtask

  task automatic t_clear_last();
    int lat, ns, l0, l1, l2, ni, gb, sb;
    fill(0, 31, 6'b000011, 8'h02);
    fill(0, 0, 6'b000111, 8'h00);
    fill(8, 8, 6'b000000, 8'h30);
    go(3'd2, 1'b0, lat, ns, l0, l1, l2, ni, gb, sb);
    chk(ns == 9, "R7 clear in last leg", ns, 9);
    chk(int'(leg) == 2 && l2 == 2, "R7 leg 2 length", l2, 2);
    chk(best == 8'h30 && success, "R8 best last leg", int'(best), 8'h30);
    chk(sb == 0, "R1 strength rows", sb, 0);
  endtask

  task automatic go_e(output int ns, output int l0, output int l1, output int l2);
    int b_s, b0, b1, b2;
    b_s = strobe_tot_e; b0 = legcnt_e[0]; b1 = legcnt_e[1]; b2 = legcnt_e[2];
    @(negedge clk);
    start_e = 1'b1;
    @(negedge clk);
    start_e = 1'b0;
    while (!done_e) @(negedge clk);
    ns = strobe_tot_e - b_s; l0 = legcnt_e[0] - b0; l1 = legcnt_e[1] - b1;
    l2 = legcnt_e[2] - b2;
  endtask

  task automatic t_gather_tie();
    int ns, l0, l1, l2;
    syn_es[0] = '0; hd_es[0] = 8'h07;
    syn_es[1] = '0; hd_es[1] = 8'h11;
    syn_es[2] = '0; hd_es[2] = 8'h03;
    go_e(ns, l0, l1, l2);
    chk(l0 == 1 && l1 == 1 && l2 == 1, "R7 valid ends leg only", l0 * 100 + l1 * 10 + l2, 111);
    chk(best_e == 8'h11, "R4 lighter kept, tie keeps earlier", int'(best_e), 8'h11);
    chk(success_e == 1'b1, "R8 gather success", int'(success_e), 1);
  endtask

  task automatic t_gather_invalid();
    int ns, l0, l1, l2;
    for (int i = 0; i < 32; i++) begin
      syn_es[i] = 6'b100000;
      hd_es[i] = 8'h00;
    end
    syn_es[1] = '0; hd_es[1] = 8'h0F;
    syn_es[2] = '0; hd_es[2] = 8'h3C;
    go_e(ns, l0, l1, l2);
    chk(ns == 9, "R4 gather strobes", ns, 9);
    chk(best_e == 8'h0F, "R4 invalid light pattern not kept", int'(best_e), 8'h0F);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear_first();
    t_no_progress();
    t_stall();
    t_stall_reset();
    t_clear_last();
    t_gather_tie();
    t_gather_invalid();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      syn_s[i] = '0; hd_s[i] = '0; syn_es[i] = '0; hd_es[i] = '0;
    end
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule